// File: doc/BRIEF.md
# Odd/Even Partial Inversion Flit Codec

This block reduces dynamic power on the wires of a network-on-chip link. The network interface does the coding end to end, and the routers stay untouched. For every flit, the encoder side builds four candidate link words from the payload:
- the payload unchanged;
- the payload with its odd-numbered bits flipped;
- the payload with its even-numbered bits flipped;
- the payload with every bit flipped.

Each candidate is scored against the word the link currently carries. The score counts the lines that toggle (self switching). It adds a weighted term for neighbouring lines that switch against each other (coupling switching). The cheapest candidate is sent, and two extra control lines tell the far side which variant was chosen.

The decoder side sits at the receiving network interface. It only XORs the received payload with a mask picked by the two control lines. Each side is one registered pipeline stage with valid/ready handshakes. A stage takes a new flit when its output register is empty or is being drained in the same cycle. The stage keeps its output steady while the downstream side stalls.

Top module: `oepi_link_codec`

## Requirements
- R1: Bit 0 of the payload counts as even. The control lines carry 2'b00 for no inversion, 2'b01 for odd-position bits flipped (mask bits 1,3,5,...), 2'b10 for even-position bits flipped (mask bits 0,2,4,...) and 2'b11 for every bit flipped.
- R2: The payload on the link equals the accepted flit XOR the mask of the mode sent beside it.
- R3: The cost of a candidate is computed over the full link word {mode, payload}, with the mode in the two top lines, against the word currently held on the link. The cost is the number of toggled lines plus CPL_WEIGHT times the sum over each adjacent line pair of: 1 when exactly one line of the pair toggles, 2 when both toggle in opposite directions, 0 otherwise.
- R4: The mode sent is one whose cost is minimal. Among equal costs, the lowest mode number is chosen.
- R5: The reference word for the cost is the last word presented on the link, mode lines included. After reset it is all zeros.
- R6: The decoder output equals the received payload XOR the mask of the received mode. Flits sent through encoder then decoder come out unchanged and in order.
- R7: While a stage's output is valid and its ready input is low, its output data, mode and valid stay unchanged.
- R8: A stage accepts a flit exactly when its output is not valid or its output is being taken. An accepted flit is valid at the output on the next cycle.
- R9: After synchronous active-low reset, both output valids are low and the link word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Encoder input flit valid |
| tx_ready | output | 1 | Encoder can accept a flit |
| tx_data | input | DATA_W | Encoder input payload |
| link_valid | output | 1 | Encoded link word valid |
| link_ready | input | 1 | Link consumer takes the word |
| link_data | output | DATA_W | Encoded payload lines |
| link_mode | output | 2 | Inversion mode control lines |
| lrx_valid | input | 1 | Received link word valid |
| lrx_ready | output | 1 | Decoder can accept a link word |
| lrx_data | input | DATA_W | Received encoded payload |
| lrx_mode | input | 2 | Received mode control lines |
| rx_valid | output | 1 | Decoded flit valid |
| rx_ready | input | 1 | Consumer takes the decoded flit |
| rx_data | output | DATA_W | Decoded payload |

## Verification
Two events can fall in the same cycle in each stage: a new flit being accepted and the held word being drained. A third can coincide with them: a stall that freezes the encoder's reference word while a later flit waits. The bench loops the link back into the decoder. It drives valid and the final ready from a seeded random source, so fill, drain and stall occur together in many orders. Directed words with known best modes come first. A bench model of the cost and the selection predicts every link word. A bench queue predicts every decoded flit. Each output is compared on the falling edge.

// File: rtl/oepi_pkg.sv
// Shared constants and helpers for the partial-inversion flit codec.
// Assumes payload widths of at most 64 bits.
package oepi_pkg;
    typedef enum logic [1:0] {
        MODE_RAW  = 2'b00,
        MODE_ODD  = 2'b01,
        MODE_EVEN = 2'b10,
        MODE_FULL = 2'b11
    } inv_mode_e;

    localparam logic [63:0] ODD_LANES  = {32{2'b10}};
    localparam logic [63:0] EVEN_LANES = {32{2'b01}};

    // Returns the 64-bit inversion mask selected by a mode code.
    function automatic logic [63:0] mode_mask(input logic [1:0] mode);
        logic [63:0] m;
        m = '0;
        if (mode[0]) m = m | ODD_LANES;
        if (mode[1]) m = m | EVEN_LANES;
        return m;
    endfunction
endpackage

// File: rtl/oepi_link_cost.sv
// Scores a candidate link word against the word on the link.
// Self term: toggled lines. Coupling term per adjacent pair: 1 for a lone
// toggle, 2 for opposite toggles, weighted by CPL_WEIGHT. Purely combinational.
module oepi_link_cost #(
    parameter int LINK_W     = 18,
    parameter int CPL_WEIGHT = 1,
    parameter int COST_W     = 8
) (
    input  logic [LINK_W-1:0] cand,
    input  logic [LINK_W-1:0] prev,
    output logic [COST_W-1:0] cost
);
    logic [LINK_W-1:0] tog;
    logic [COST_W-1:0] self_sum;
    logic [COST_W-1:0] cpl_sum;

    // Sum self and coupling transitions over all lines and pairs.
    always_comb begin
        tog      = cand ^ prev;
        self_sum = '0;
        cpl_sum  = '0;
        for (int i = 0; i < LINK_W; i++)
            self_sum = self_sum + COST_W'(tog[i]);
        for (int i = 0; i < LINK_W - 1; i++) begin
            if (tog[i] && tog[i+1] && (cand[i] != cand[i+1]))
                cpl_sum = cpl_sum + COST_W'(2);
            else if (tog[i] != tog[i+1])
                cpl_sum = cpl_sum + COST_W'(1);
        end
        cost = self_sum + COST_W'(CPL_WEIGHT) * cpl_sum;
    end
endmodule

// File: rtl/oepi_encoder.sv
// Encoder stage: builds four inversion candidates, picks the cheapest
// against the held link word (ties to the lower mode) and registers it.
// Assumes DATA_W <= 64. Holds its output while out_ready is low.
module oepi_encoder #(
    parameter int DATA_W     = 16,
    parameter int CPL_WEIGHT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_mode
);
    import oepi_pkg::*;

    localparam int LINK_W = DATA_W + 2;
    localparam int COST_W = $clog2((3 * LINK_W) * (CPL_WEIGHT + 1) + 1) + 1;
    localparam int NCAND  = 4;

    logic [LINK_W-1:0] prev_word;
    logic [LINK_W-1:0] cand  [NCAND];
    logic [COST_W-1:0] costs [NCAND];
    logic [1:0]        best_mode;
    logic [COST_W-1:0] best_cost;
    logic              accept;

    assign prev_word = {out_mode, out_data};
    assign in_ready  = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;

    for (genvar m = 0; m < NCAND; m++) begin : g_cand
        assign cand[m] = {2'(m), in_data ^ mode_mask(2'(m))[DATA_W-1:0]};
        oepi_link_cost #(
            .LINK_W(LINK_W), .CPL_WEIGHT(CPL_WEIGHT), .COST_W(COST_W)
        ) cost_i (
            .cand(cand[m]), .prev(prev_word), .cost(costs[m])
        );
    end

    // Pick the cheapest candidate; strict compare keeps the lower mode on ties.
    always_comb begin
        best_mode = 2'd0;
        best_cost = costs[0];
        for (int m = 1; m < NCAND; m++) begin
            if (costs[m] < best_cost) begin
                best_mode = 2'(m);
                best_cost = costs[m];
            end
        end
    end

    // Register the selected word; drop valid once drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_mode  <= 2'b00;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= cand[best_mode][DATA_W-1:0];
            out_mode  <= best_mode;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    p_min_cost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (best_cost <= costs[0]) && (best_cost <= costs[1])
                && (best_cost <= costs[2]) && (best_cost <= costs[3]));
    p_hold_enc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mode));
    p_accept_enc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    p_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_data ^ mode_mask(out_mode)[DATA_W-1:0]) == $past(in_data));
    p_reset_enc_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid && out_data == '0 && out_mode == 2'b00);
endmodule

// File: rtl/oepi_decoder.sv
// Decoder stage: XORs the received payload with the mask chosen by the
// mode lines and registers the result. Holds its output while out_ready is low.
module oepi_decoder #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    import oepi_pkg::*;

    logic accept;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Register the restored payload; drop valid once drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= in_data ^ mode_mask(in_mode)[DATA_W-1:0];
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    p_hold_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    p_accept_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
    p_reset_dec_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: rtl/oepi_link_codec.sv
// Top: encoder half for the sending network interface and decoder half
// for the receiving one. The halves share only clock and reset.
module oepi_link_codec #(
    parameter int DATA_W     = 16,
    parameter int CPL_WEIGHT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    output logic              link_valid,
    input  logic              link_ready,
    output logic [DATA_W-1:0] link_data,
    output logic [1:0]        link_mode,
    input  logic              lrx_valid,
    output logic              lrx_ready,
    input  logic [DATA_W-1:0] lrx_data,
    input  logic [1:0]        lrx_mode,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data
);
    oepi_encoder #(.DATA_W(DATA_W), .CPL_WEIGHT(CPL_WEIGHT)) enc_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
        .out_valid(link_valid), .out_ready(link_ready),
        .out_data(link_data), .out_mode(link_mode)
    );

    oepi_decoder #(.DATA_W(DATA_W)) dec_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(lrx_valid), .in_ready(lrx_ready),
        .in_data(lrx_data), .in_mode(lrx_mode),
        .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
    );
endmodule

// File: tb/oepi_link_codec_tb_top.sv
// Loopback bench: link outputs feed the decoder inputs. A bench model of
// cost and selection predicts link words; a queue predicts decoded flits.
module oepi_link_codec_tb_top;
    localparam int DW = 16;
    localparam int LW = DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0, rx_ready = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic tx_ready, link_valid, link_ready, lrx_ready, rx_valid;
    logic [DW-1:0] link_data, rx_data;
    logic [1:0] link_mode;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    oepi_link_codec #(.DATA_W(DW), .CPL_WEIGHT(1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .link_valid(link_valid), .link_ready(link_ready),
        .link_data(link_data), .link_mode(link_mode),
        .lrx_valid(link_valid), .lrx_ready(lrx_ready),
        .lrx_data(link_data), .lrx_mode(link_mode),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );
    assign link_ready = lrx_ready;

    // expected state
    logic          e_lv = 0, e_rv = 0;
    logic [DW-1:0] e_ld = '0, e_rd = '0;
    logic [1:0]    e_lm = 2'b00;
    logic [DW-1:0] pend[$];

    function automatic logic [DW-1:0] mask_of(input logic [1:0] m);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < DW; i++)
            if ((i % 2 == 1 && m[0]) || (i % 2 == 0 && m[1])) r[i] = 1'b1;
        return r;
    endfunction

    function automatic int cost_of(input logic [LW-1:0] c, input logic [LW-1:0] p);
        int s = 0;
        for (int i = 0; i < LW; i++) if (c[i] != p[i]) s++;
        for (int i = 0; i < LW - 1; i++) begin
            logic ti = c[i] != p[i];
            logic tj = c[i+1] != p[i+1];
            if (ti && tj && c[i] != c[i+1]) s += 2;
            else if (ti != tj) s += 1;
        end
        return s;
    endfunction

    function automatic logic [1:0] pick(input logic [DW-1:0] d, input logic [LW-1:0] p);
        logic [1:0] b = 2'd0;
        int bc = cost_of({2'd0, d}, p);
        for (int m = 1; m < 4; m++) begin
            int c = cost_of({2'(m), d ^ mask_of(2'(m))}, p);
            if (c < bc) begin bc = c; b = 2'(m); end
        end
        return b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        check("R8 link_valid", 32'(link_valid), 32'(e_lv));
        if (e_lv) begin
            check("R4 link_mode", 32'(link_mode), 32'(e_lm));
            check("R2 link_data", 32'(link_data), 32'(e_ld));
        end
        check("R8 rx_valid", 32'(rx_valid), 32'(e_rv));
        if (e_rv) check("R6 rx_data", 32'(rx_data), 32'(e_rd));
    endtask

    // One cycle: compare, drive, predict the coming edge.
    task automatic step(input logic v, input logic [DW-1:0] d, input logic rr);
        logic enc_acc, dec_acc, rx_take;
        @(negedge clk);
        compare_outputs();
        tx_valid = v; tx_data = d; rx_ready = rr;
        #1;
        enc_acc = tx_valid && tx_ready;
        dec_acc = link_valid && link_ready;
        rx_take = rx_valid && rx_ready;
        if (dec_acc) begin e_rv = 1; e_rd = pend.pop_front(); end
        else if (rx_take) e_rv = 0;
        if (enc_acc) begin
            e_lm = pick(d, {e_lm, e_ld});   // R5 reference is held link word
            e_ld = d ^ mask_of(e_lm);
            e_lv = 1;
            pend.push_back(d);
        end else if (dec_acc) e_lv = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check("R9 link_valid", 32'(link_valid), 0);
        check("R9 rx_valid", 32'(rx_valid), 0);
        check("R9 link word", 32'({link_mode, link_data}), 0);
        // R1 directed: 0xAAAA from all-zero link goes odd-inverted
        step(1, 16'hAAAA, 1);
        step(0, '0, 1);
        check("R1 odd mode", 32'(link_mode), 32'(2'b01));
        check("R1 odd payload", 32'(link_data), 0);
        // R1 directed: 0x5555 after {01,0000} goes even-inverted
        step(1, 16'h5555, 1);
        step(0, '0, 1);
        check("R1 even mode", 32'(link_mode), 32'(2'b10));
        check("R1 even payload", 32'(link_data), 0);
        // R3/R4 corner words back to back
        step(1, 16'hFFFF, 1);
        step(1, 16'h0000, 1);
        step(1, 16'h0001, 1);
        step(1, 16'h8000, 1);
        step(1, 16'hF0F0, 1);
        // R7 stall with producer pushing: both stages fill and hold
        step(1, 16'h1234, 0);
        step(1, 16'h4321, 0);
        step(1, 16'h5A5A, 0);
        step(1, 16'h5A5A, 0);
        check("R7 tx_ready low when full", 32'(tx_ready), 0);
        step(0, '0, 1);
        step(0, '0, 1);
        step(0, '0, 1);
        // random mix of fill, drain and stall (R2 R4 R5 R6 R7 R8)
        for (int n = 0; n < 4000; n++)
            step(($urandom % 4) != 0, 16'($urandom), ($urandom % 3) != 0);
        for (int n = 0; n < 4; n++) step(0, '0, 1);
        check("R6 queue drained", 32'(pend.size()), 0);
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule